// File: doc/BRIEF.md
# Interrupt Acknowledge Cycle Controller

This block fetches an interrupt vector from an external interrupt controller. When the interrupt logic raises a request, the block runs two consecutive bus cycles. Each cycle has the phase timing of a read cycle, but the block drives a dedicated acknowledge strobe and leaves the read strobe idle. A lock output stays high across both cycles, so no other bus master can split the pair.

The block ignores the data on the bus during the first cycle. In the second cycle it samples only the low byte of the 16-bit data bus, because the upper byte floats. It passes that byte to the processor side with a one-clock valid pulse. The vector output then holds that value until the next sequence completes.

Top module: `iack_ctrl`

## Requirements
- R1: Each accepted request produces exactly two bus cycles, each seen as one contiguous run of the acknowledge strobe.
- R2: The lock output rises at T1 of the first cycle and stays high, without a gap, until the end of T4 of the second cycle. With w1 and w2 wait states it is high for 8 + w1 + w2 clocks.
- R3: The read strobe output stays low at all times.
- R4: In each cycle the acknowledge strobe is high from T2 through T3 and every wait state, which is 2 + w clocks for w wait states. It is low in T1 and T4.
- R5: The ready input is sampled at the end of T3 and of each wait state. While ready is low, another wait state is inserted.
- R6: The vector equals data bits 7:0 as sampled at the end of the last strobe phase of the second cycle. Bits 15:8 have no effect on it.
- R7: Data on the bus during the first cycle does not change the vector output.
- R8: The vector valid output is high for exactly one clock per sequence, during T4 of the second cycle, which is the last clock in which lock is high.
- R9: Between valid pulses the vector output keeps the last captured value, whatever is on the data bus.
- R10: A request raised while a sequence is running is ignored. The sequence length does not change, and no new sequence starts after it ends.
- R11: After reset, lock, the acknowledge strobe, the read strobe and the valid output are low, and the vector output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start request, sampled while idle |
| rdy_i | input | 1 | Bus ready, sampled at the end of T3 and of each wait state |
| data_i | input | 16 | Bus data; only bits 7:0 of the second cycle are used |
| lock_o | output | 1 | Bus lock across both cycles |
| ack_o | output | 1 | Acknowledge strobe, active high |
| rd_o | output | 1 | Read strobe, always inactive |
| vec_o | output | 8 | Captured vector |
| vec_valid_o | output | 1 | One-clock pulse when vec_o is updated |

## Verification
A request sampled at a clock edge puts the block in T1 on that edge. With no wait states, valid arrives in the 8th clock of lock and lock falls one clock later. Each wait state pushes both events out by one clock. The driver sets ready on the falling edge of each strobe clock, using the number of strobe clocks seen so far, so ready is stable at the edge that samples it. The monitor samples every output on the falling edge and counts lock, strobe and valid clocks per sequence. When lock falls it compares those counts, and the vector seen with valid, against the item the driver queued.

// File: rtl/iack_pkg.sv
package iack_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5
  } phase_e;
endpackage

// File: rtl/iack_seq.sv
module iack_seq
  import iack_pkg::*;
#(
  parameter int CYCLES = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   req_i,
  input  logic   rdy_i,
  output phase_e phase_o,
  output logic   lock_o,
  output logic   ack_o,
  output logic   cap_o
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cyc_q, cyc_d;
  logic             strobe_end;

  assign strobe_end = (phase_q == PH_T3 || phase_q == PH_TW) && rdy_i;

  always_comb begin
    phase_d = phase_q;
    cyc_d   = cyc_q;
    unique case (phase_q)
      PH_IDLE: if (req_i) begin
        phase_d = PH_T1;
        cyc_d   = '0;
      end
      PH_T1: phase_d = PH_T2;
      PH_T2: phase_d = PH_T3;
      PH_T3, PH_TW: phase_d = rdy_i ? PH_T4 : PH_TW;
      PH_T4: begin
        if (cyc_q == LAST) phase_d = PH_IDLE;
        else begin
          phase_d = PH_T1;
          cyc_d   = cyc_q + 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cyc_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cyc_q   <= cyc_d;
    end
  end

  assign phase_o = phase_q;
  assign lock_o  = (phase_q != PH_IDLE);
  assign ack_o   = (phase_q == PH_T2) || (phase_q == PH_T3) || (phase_q == PH_TW);
  // only the final cycle's sample is kept
  assign cap_o   = strobe_end && (cyc_q == LAST);

  // R2
  ack_under_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> lock_o);
  // R4
  ack_after_t1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_T1) |=> ack_o);
  // R5
  wait_insert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase_q == PH_T3 || phase_q == PH_TW) && !rdy_i) |=> ack_o);
  // R10
  req_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_T2 && req_i) |=> (phase_q == PH_T3));
endmodule

// File: rtl/iack_capture.sv
module iack_capture #(
  parameter int DATA_W = 16,
  parameter int VEC_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [VEC_W-1:0]  vec_o,
  output logic              valid_o
);
  logic [VEC_W-1:0] low_byte;

  generate
    if (DATA_W == VEC_W) begin : g_full
      assign low_byte = data_i;
    end else begin : g_slice
      assign low_byte = data_i[VEC_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= cap_i;
      if (cap_i) vec_o <= low_byte;
    end
  end

  // R8
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R9
  vec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(vec_o));
endmodule

// File: rtl/iack_ctrl.sv
module iack_ctrl
  import iack_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int VEC_W  = 8,
  parameter int CYCLES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              rdy_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              lock_o,
  output logic              ack_o,
  output logic              rd_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              vec_valid_o
);
  phase_e phase;
  logic   cap;

  iack_seq #(.CYCLES(CYCLES)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .rdy_i   (rdy_i),
    .phase_o (phase),
    .lock_o  (lock_o),
    .ack_o   (ack_o),
    .cap_o   (cap)
  );

  iack_capture #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap),
    .data_i  (data_i),
    .vec_o   (vec_o),
    .valid_o (vec_valid_o)
  );

  assign rd_o = 1'b0;

  // R8
  valid_in_t4_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> (lock_o && phase == PH_T4));
endmodule

// File: tb/tb_iack_ctrl.sv
module tb_iack_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        rdy_i = 1'b0;
  logic [15:0] data_i = 16'h0;
  logic        lock_o, ack_o, rd_o, vec_valid_o;
  logic [7:0]  vec_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] vec; int len; int acks; } item_t;
  item_t q[$];

  iack_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .rdy_i(rdy_i), .data_i(data_i),
    .lock_o(lock_o), .ack_o(ack_o), .rd_o(rd_o), .vec_o(vec_o), .vec_valid_o(vec_valid_o)
  );

  always #4 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: queues expected item, runs stimulus for one sequence
  task automatic run_seq(input logic [7:0] vec, input int w1, input int w2, input bit poke);
    item_t it;
    int k = 0;
    int cyc = 0;
    int n = 0;
    it.vec = vec; it.len = 8 + w1 + w2; it.acks = 4 + w1 + w2;
    q.push_back(it);
    @(negedge clk_i);
    req_i = 1'b1;
    data_i = {~vec, ~vec};
    @(negedge clk_i);
    req_i = 1'b0;
    while (lock_o) begin
      n++;
      req_i = poke && (n == 3 || n == 7);
      if (ack_o) begin
        k++;
        rdy_i = (k >= 2 + ((cyc == 0) ? w1 : w2));
      end else if (k > 0) begin
        k = 0;
        cyc++;
        rdy_i = 1'b0;
        data_i = {vec ^ 8'h5A, vec};
      end
      @(negedge clk_i);
    end
    req_i = 1'b0;
    rdy_i = 1'b0;
  endtask

  // monitor
  int  run_len = 0, ack_hi = 0, ack_runs = 0, val_cnt = 0, val_pos = 0;
  bit  prev_ack = 0, moved = 0;
  logic [7:0] old_vec, got_vec;
  int  rd_bad = 0;

  initial begin
    forever begin
      @(negedge clk_i);
      if (!rst_ni) continue;
      if (rd_o) rd_bad++;
      if (lock_o) begin
        if (run_len == 0) old_vec = vec_o;
        run_len++;
        if (ack_o) ack_hi++;
        if (ack_o && !prev_ack) ack_runs++;
        if (vec_valid_o) begin
          val_cnt++; val_pos = run_len; got_vec = vec_o;
        end else if (val_cnt == 0 && vec_o != old_vec) moved = 1;
        prev_ack = ack_o;
      end else if (run_len > 0) begin
        item_t e;
        if (q.size() == 0) chk(0, "R10 unexpected sequence", run_len, 0);
        else begin
          e = q.pop_front();
          chk(ack_runs == 2, "R1 strobe runs", ack_runs, 2);
          chk(run_len == e.len, "R2 lock length", run_len, e.len);
          chk(ack_hi == e.acks, "R4 R5 strobe clocks", ack_hi, e.acks);
          chk(val_cnt == 1, "R8 valid count", val_cnt, 1);
          chk(val_pos == e.len, "R8 valid position", val_pos, e.len);
          chk(got_vec == e.vec, "R6 vector", got_vec, e.vec);
          chk(!moved, "R7 vec moved in first cycle", moved, 0);
        end
        run_len = 0; ack_hi = 0; ack_runs = 0; val_cnt = 0; val_pos = 0;
        prev_ack = 0; moved = 0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #2;
    chk(lock_o == 0, "R11 lock", lock_o, 0);
    chk(ack_o == 0, "R11 ack", ack_o, 0);
    chk(vec_valid_o == 0, "R11 valid", vec_valid_o, 0);
    chk(vec_o == 0, "R11 vec", vec_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(lock_o == 0, "R11 idle lock", lock_o, 0);

    run_seq(8'hA5, 0, 0, 0);
    run_seq(8'h3C, 2, 0, 0);
    run_seq(8'h00, 0, 3, 0);
    run_seq(8'hFF, 1, 1, 1);
    repeat (4) begin
      @(negedge clk_i);
      chk(lock_o == 0, "R10 no restart", lock_o, 0);
    end
    run_seq(8'h81, 4, 2, 0);
    data_i = 16'h1234;
    repeat (5) @(negedge clk_i);
    chk(vec_o == 8'h81, "R9 vector held", vec_o, 8'h81);
    chk(rd_bad == 0, "R3 read strobe", rd_bad, 0);
    chk(q.size() == 0, "R1 pending items", q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule